// File: doc/BRIEF.md
# UART Modem-Control Loopback

This block sits between a UART's register file, its external modem pins, its external receiver and its receive FIFO. It supplies the internal self-test path. With the loopback enable field of the control register set, the four software-driven modem-control outputs are routed onto the four modem-status flags. The modem-status interrupt bits are rebuilt from those flags on every control-register write. Each transmitted character, and each newly asserted break, is fed straight into the receive FIFO write port. Characters from the external receiver are accepted and thrown away.

With loopback off, the modem-status flags follow the external modem input pins through a two-flop synchronizer. A flag that changes raises its interrupt bit. External receive characters pass to the FIFO write port.

The FIFO write port is a valid/ready stream held in one registered slot. Once `rxq_valid` is high, `rxq_data` stays constant until a cycle in which `rxq_ready` is high. The external receive stream is also valid/ready: a character is taken in any cycle where `ext_rx_valid` and `ext_rx_ready` are both high. Loopback pushes come from strobes that have no ready. A loopback push that arrives while the slot is held by back-pressure is dropped, just as a full FIFO would drop it. Control and status pins are plain levels or single-cycle strobes.

Top module: `uart_loopback_ctl`

## Requirements
- R1: After reset, `ms_flags`, `ms_irq_set`, `ms_irq_clr` and `rxq_valid` are all zero.
- R2: A cycle with `cfg_wr` high and `cfg_lbk_en` high loads `ms_flags` on that clock edge, using bit 0 (CTS) from `cfg_rts`, bit 1 (DSR) from `cfg_dtr`, bit 2 (DCD) from `cfg_out1` and bit 3 (RI) from `cfg_out2`. The flags then hold, whatever the modem pins do, until the next such write.
- R3: A control write whose only change is setting `cfg_lbk_en` applies the R2 mapping at once, using the control bits already present.
- R4: In the cycle after each loopback control write, `ms_irq_clr` is 4'b1111 for one cycle and `ms_irq_set` equals the new flags, in the R2 bit order. The consumer applies the clear first and then the set.
- R5: With `cfg_lbk_en` low, `ms_flags` follows `modem_in` (same bit order) three clock edges after the pins change. In that same cycle, `ms_irq_set` pulses the bits that changed and `ms_irq_clr` stays zero. A control write has no effect on the flags.
- R6: With loopback on, a `tx_wr` strobe places `{3'b000, tx_data}` on the FIFO port on the next edge.
- R7: With loopback on, `brk_chg` with `brk_level` high places a break word on the FIFO port: bit 10 set and all other bits zero. `brk_chg` with `brk_level` low pushes nothing.
- R8: When a break push and a `tx_wr` strobe arrive in the same loopback cycle, only the break word is pushed and the character is dropped.
- R9: With loopback on, `ext_rx_ready` is high and external characters never reach the FIFO port.
- R10: With loopback off, an external character is forwarded as `{3'b000, ext_rx_data}`, and `tx_wr` and break events push nothing.
- R11: While `rxq_valid` is high and `rxq_ready` is low, the slot keeps its data and `ext_rx_ready` is low with loopback off. Loopback pushes arriving in that time are lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Control-register write strobe |
| cfg_lbk_en | input | 1 | Loopback enable field |
| cfg_out2 | input | 1 | Out2 control bit |
| cfg_out1 | input | 1 | Out1 control bit |
| cfg_rts | input | 1 | Request-to-send control bit |
| cfg_dtr | input | 1 | Data-terminal-ready control bit |
| tx_wr | input | 1 | Transmit data write strobe |
| tx_data | input | 8 | Transmitted character |
| brk_chg | input | 1 | Send-break bit changed |
| brk_level | input | 1 | New value of the send-break bit |
| modem_in | input | 4 | External modem pins {RI, DCD, DSR, CTS} |
| ext_rx_valid | input | 1 | External receiver character valid |
| ext_rx_data | input | 8 | External receiver character |
| ext_rx_ready | output | 1 | External character accepted |
| ms_flags | output | 4 | Modem-status flags {RI, DCD, DSR, CTS} |
| ms_irq_set | output | 4 | Modem interrupt set bits |
| ms_irq_clr | output | 4 | Modem interrupt clear bits |
| rxq_valid | output | 1 | FIFO write request valid |
| rxq_data | output | 11 | FIFO write word; bit 10 marks a break |
| rxq_ready | input | 1 | FIFO accepts the word |

## Verification
The hardest state to reach is a loopback push landing on a slot that is held by back-pressure. The bench holds `rxq_ready` low, fills the slot with a transmitted character, strobes a second character, and then confirms that the first word is still on the port and that the second never appears. A break and a character in the same cycle is also reached only on purpose: both strobes are driven in one cycle and the bench checks that the break word is pushed and nothing follows it. The loopback-enable-only write is reached by first leaving loopback with every control bit already set. A write that then changes only the enable bit shows all four flags jump together.

// File: rtl/uart_lb_pkg.sv
package uart_lb_pkg;
  // modem-status bit positions shared by flags, interrupts and pins
  localparam int MS_W   = 4;
  localparam int MS_CTS = 0;
  localparam int MS_DSR = 1;
  localparam int MS_DCD = 2;
  localparam int MS_RI  = 3;

  typedef logic [MS_W-1:0] ms_vec_t;

  function automatic ms_vec_t map_ctrl(input logic out2, input logic out1,
                                       input logic rts, input logic dtr);
    ms_vec_t v;
    v         = '0;
    v[MS_CTS] = rts;
    v[MS_DSR] = dtr;
    v[MS_DCD] = out1;
    v[MS_RI]  = out2;
    return v;
  endfunction
endpackage

// File: rtl/lb_sync.sv
module lb_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= '0;
        else if (s == 0) chain[s] <= d;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/lb_modem_status.sv
module lb_modem_status
  import uart_lb_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    cfg_wr,
  input  logic    lb_en,
  input  ms_vec_t ctrl_map,
  input  ms_vec_t pins_sync,
  output ms_vec_t flags,
  output ms_vec_t irq_set,
  output ms_vec_t irq_clr
);
  logic lb_update;
  assign lb_update = cfg_wr && lb_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags   <= '0;
      irq_set <= '0;
      irq_clr <= '0;
    end else if (lb_update) begin
      flags   <= ctrl_map;
      irq_set <= ctrl_map;
      irq_clr <= '1;
    end else if (!lb_en) begin
      flags   <= pins_sync;
      irq_set <= flags ^ pins_sync;
      irq_clr <= '0;
    end else begin
      irq_set <= '0;
      irq_clr <= '0;
    end
  end

  // R2: loopback write lands the mapped control bits on the flags
  assert_map_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lb_update |=> flags == $past(ctrl_map));
  // R4: a clear pulse always clears every bit and carries the new flags
  assert_clr_all_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_clr) |-> (irq_clr == '1) && (irq_set == flags));
  // R5: pin-following mode never raises clear lines
  assert_pin_noclr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !lb_en |=> irq_clr == '0);
  // R2: flags hold while in loopback without a write
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (lb_en && !cfg_wr) |=> $stable(flags));
endmodule

// File: rtl/lb_rx_feed.sv
module lb_rx_feed #(
  parameter int DATA_W  = 8,
  localparam int ENTRY_W = DATA_W + 3,
  localparam int BRK_BIT = ENTRY_W - 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lb_en,
  input  logic               tx_push,
  input  logic [DATA_W-1:0]  tx_data,
  input  logic               brk_chg,
  input  logic               brk_level,
  input  logic               ext_valid,
  input  logic [DATA_W-1:0]  ext_data,
  output logic               ext_ready,
  output logic               q_valid,
  output logic [ENTRY_W-1:0] q_data,
  input  logic               q_ready
);
  localparam logic [ENTRY_W-1:0] BRK_WORD = ENTRY_W'(1) << BRK_BIT;

  logic slot_free, brk_push, chr_push, ext_take, load;
  logic [ENTRY_W-1:0] next_word;

  assign slot_free = !q_valid || q_ready;
  assign brk_push  = lb_en && brk_chg && brk_level;
  assign chr_push  = lb_en && tx_push && !brk_push;
  assign ext_take  = !lb_en && ext_valid && slot_free;
  assign ext_ready = lb_en ? 1'b1 : slot_free;
  assign load      = slot_free && (brk_push || chr_push || ext_take);

  always_comb begin
    if (brk_push)      next_word = BRK_WORD;
    else if (chr_push) next_word = {3'b000, tx_data};
    else               next_word = {3'b000, ext_data};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_data  <= '0;
    end else if (load) begin
      q_valid <= 1'b1;
      q_data  <= next_word;
    end else if (q_ready) begin
      q_valid <= 1'b0;
    end
  end

  // R11: a stalled word stays put
  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (q_valid && !q_ready) |=> q_valid && $stable(q_data));
  // R7: a break word carries no character bits
  assert_brk_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (q_valid && q_data[BRK_BIT]) |-> (q_data[DATA_W-1:0] == '0));
  // R9: in loopback, external data alone never fills the slot
  assert_ext_blocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (lb_en && !tx_push && !(brk_chg && brk_level) && slot_free) |=> !q_valid);
  // R10: loopback strobes push nothing when loopback is off
  assert_off_nopush_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!lb_en && !ext_valid && slot_free) |=> !q_valid);
endmodule

// File: rtl/uart_loopback_ctl.sv
module uart_loopback_ctl
  import uart_lb_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int ENTRY_W    = DATA_W + 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr,
  input  logic               cfg_lbk_en,
  input  logic               cfg_out2,
  input  logic               cfg_out1,
  input  logic               cfg_rts,
  input  logic               cfg_dtr,
  input  logic               tx_wr,
  input  logic [DATA_W-1:0]  tx_data,
  input  logic               brk_chg,
  input  logic               brk_level,
  input  logic [MS_W-1:0]    modem_in,
  input  logic               ext_rx_valid,
  input  logic [DATA_W-1:0]  ext_rx_data,
  output logic               ext_rx_ready,
  output logic [MS_W-1:0]    ms_flags,
  output logic [MS_W-1:0]    ms_irq_set,
  output logic [MS_W-1:0]    ms_irq_clr,
  output logic               rxq_valid,
  output logic [ENTRY_W-1:0] rxq_data,
  input  logic               rxq_ready
);
  ms_vec_t pins_sync, ctrl_map;

  assign ctrl_map = map_ctrl(cfg_out2, cfg_out1, cfg_rts, cfg_dtr);

  lb_sync #(.WIDTH(MS_W), .STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(rst_n), .d(modem_in), .q(pins_sync)
  );

  lb_modem_status i_status (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .lb_en(cfg_lbk_en),
    .ctrl_map(ctrl_map), .pins_sync(pins_sync),
    .flags(ms_flags), .irq_set(ms_irq_set), .irq_clr(ms_irq_clr)
  );

  lb_rx_feed #(.DATA_W(DATA_W)) i_feed (
    .clk(clk), .rst_n(rst_n), .lb_en(cfg_lbk_en),
    .tx_push(tx_wr), .tx_data(tx_data),
    .brk_chg(brk_chg), .brk_level(brk_level),
    .ext_valid(ext_rx_valid), .ext_data(ext_rx_data), .ext_ready(ext_rx_ready),
    .q_valid(rxq_valid), .q_data(rxq_data), .q_ready(rxq_ready)
  );
endmodule

// File: tb/test_uart_loopback_ctl.sv
module test_uart_loopback_ctl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_wr = 0, cfg_lbk_en = 0, cfg_out2 = 0, cfg_out1 = 0, cfg_rts = 0, cfg_dtr = 0;
  logic tx_wr = 0, brk_chg = 0, brk_level = 0, ext_rx_valid = 0, rxq_ready = 1;
  logic [7:0] tx_data = '0, ext_rx_data = '0;
  logic [3:0] modem_in = '0;
  logic ext_rx_ready, rxq_valid;
  logic [3:0] ms_flags, ms_irq_set, ms_irq_clr;
  logic [10:0] rxq_data;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  uart_loopback_ctl i_uart_loopback_ctl (.*);

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s actual=%h expected=%h", tag, act, exp); end
  endtask

  task automatic ctrl_write(input bit lb, input logic [3:0] o);  // o = {out2,out1,dtr,rts}
    cfg_lbk_en = lb; {cfg_out2, cfg_out1, cfg_dtr, cfg_rts} = o; cfg_wr = 1;
    tick(); cfg_wr = 0;
  endtask

  task automatic t_reset();
    chk(ms_flags == 0 && ms_irq_set == 0 && ms_irq_clr == 0 && !rxq_valid, "R1 reset",
        {ms_flags, ms_irq_set, ms_irq_clr, 3'b0, rxq_valid}, 16'h0);
  endtask

  task automatic t_pins();
    modem_in = 4'b0101; tick(); tick();
    chk(ms_flags == 4'b0000, "R5 latency", ms_flags, 0);
    tick();
    chk(ms_flags == 4'b0101 && ms_irq_set == 4'b0101 && ms_irq_clr == 0, "R5 follow",
        {ms_flags, ms_irq_set, ms_irq_clr}, 12'h550);
    ctrl_write(0, 4'b1010);
    chk(ms_flags == 4'b0101 && ms_irq_set == 0, "R5 write ignored", {ms_flags, ms_irq_set}, 8'h50);
  endtask

  task automatic t_map();
    // out2=1 out1=0 rts=1 dtr=0 -> RI=1 DCD=0 DSR=0 CTS=1
    ctrl_write(1, 4'b1000 | 4'b0001);
    chk(ms_flags == 4'b1001, "R2 map a", ms_flags, 4'b1001);
    chk(ms_irq_clr == 4'hF && ms_irq_set == 4'b1001, "R4 irq a", {ms_irq_clr, ms_irq_set}, 8'hF9);
    tick();
    chk(ms_irq_clr == 0 && ms_irq_set == 0, "R4 one cycle", {ms_irq_clr, ms_irq_set}, 0);
    // out1=1 dtr=1 -> DCD=1 DSR=1
    ctrl_write(1, 4'b0110);
    chk(ms_flags == 4'b0110 && ms_irq_set == 4'b0110, "R2 map b", {ms_flags, ms_irq_set}, 8'h66);
    modem_in = 4'b1111; repeat (4) tick();
    chk(ms_flags == 4'b0110, "R2 hold vs pins", ms_flags, 4'b0110);
  endtask

  task automatic t_lbk_only();
    modem_in = 4'b0000;
    ctrl_write(0, 4'b1111); repeat (4) tick();
    chk(ms_flags == 4'b0000, "R3 pins before", ms_flags, 0);
    ctrl_write(1, 4'b1111);
    chk(ms_flags == 4'b1111 && ms_irq_set == 4'b1111, "R3 enable only", {ms_flags, ms_irq_set}, 8'hFF);
  endtask

  task automatic t_tx();
    rxq_ready = 1; tx_data = 8'hA5; tx_wr = 1; tick(); tx_wr = 0;
    chk(rxq_valid && rxq_data == 11'h0A5, "R6 tx loop", {4'b0, rxq_valid, rxq_data}, 16'h08A5);
    tick();
    chk(!rxq_valid, "R6 consumed", rxq_valid, 0);
  endtask

  task automatic t_break();
    brk_chg = 1; brk_level = 1; tick(); brk_chg = 0;
    chk(rxq_valid && rxq_data == 11'h400, "R7 break word", {4'b0, rxq_valid, rxq_data}, 16'h0C00);
    brk_chg = 1; brk_level = 0; tick(); brk_chg = 0;
    chk(!rxq_valid, "R7 falling no push", rxq_valid, 0);
    brk_chg = 1; brk_level = 1; tx_data = 8'h3C; tx_wr = 1; tick(); brk_chg = 0; tx_wr = 0;
    chk(rxq_valid && rxq_data == 11'h400, "R8 break wins", {4'b0, rxq_valid, rxq_data}, 16'h0C00);
    tick();
    chk(!rxq_valid, "R8 char dropped", {5'b0, rxq_valid, rxq_data}, 0);
  endtask

  task automatic t_ext_lbk();
    rxq_ready = 0; ext_rx_valid = 1; ext_rx_data = 8'h55; #1;
    chk(ext_rx_ready, "R9 ready in loopback", ext_rx_ready, 1);
    tick(); ext_rx_valid = 0; rxq_ready = 1;
    chk(!rxq_valid, "R9 discarded", rxq_valid, 0);
  endtask

  task automatic t_ext_off();
    ctrl_write(0, 4'b0000);
    ext_rx_valid = 1; ext_rx_data = 8'h77; tick(); ext_rx_valid = 0;
    chk(rxq_valid && rxq_data == 11'h077, "R10 forward", {4'b0, rxq_valid, rxq_data}, 16'h0877);
    tx_data = 8'h99; tx_wr = 1; brk_chg = 1; brk_level = 1; tick(); tx_wr = 0; brk_chg = 0;
    chk(!rxq_valid, "R10 no loop push", rxq_valid, 0);
  endtask

  task automatic t_backpressure();
    rxq_ready = 0; ext_rx_valid = 1; ext_rx_data = 8'h12; tick(); ext_rx_valid = 0;
    chk(rxq_valid && rxq_data == 11'h012, "R11 slot filled", rxq_data, 11'h012);
    chk(!ext_rx_ready, "R11 ext stalled", ext_rx_ready, 0);
    rxq_ready = 1; tick();
    ctrl_write(1, 4'b0000);
    rxq_ready = 0; tx_data = 8'h11; tx_wr = 1; tick();
    tx_data = 8'h22; tick(); tx_wr = 0; tick();
    chk(rxq_valid && rxq_data == 11'h011, "R11 held", {4'b0, rxq_valid, rxq_data}, 16'h0811);
    rxq_ready = 1; tick();
    chk(!rxq_valid, "R11 stalled push lost", {5'b0, rxq_valid, rxq_data}, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk); #1; rst_n = 1;
    t_reset(); t_pins(); t_map(); t_lbk_only(); t_tx(); t_break();
    t_ext_lbk(); t_ext_off(); t_backpressure();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule